// File: doc/BRIEF.md
# Decimal Multiplier by Binary Round-Trip

This block multiplies two unsigned decimal numbers held as packed BCD (five digits each by default) and returns their exact product as packed BCD, twice as many digits wide. It does not form decimal partial products. Each operand is first turned into a binary integer by a multiply-by-ten-and-add walk over its digits. The two binary values then go through one plain unsigned multiply. The binary product is converted back to decimal in two steps. The first step regroups it into base-1000 digits, using a Horner recurrence over 10-bit slices, where each step computes "times 1024 = times 1000 plus times 24". The second step expands every base-1000 digit into three BCD digits with shift-and-add-3.

The datapath has two register stages. Stage one holds the binary product and stage two holds the BCD result. The block takes a new operand pair on every clock and gives no back-pressure. A valid strobe travels alongside the data. Operand nibbles above 9 break the input contract and are not detected.

Top module: `bcd_rt_mult`

## Requirements
- R1: Each operand's BCD-to-binary conversion yields its decimal value, so that multiplying an operand by 1 returns that operand unchanged in BCD.
- R2: For any two operands, `prod_bcd` carries the exact decimal product as packed BCD. Digit k sits in bits [4k+3:4k], so the least significant digit is in the low nibble, and leading zeros are kept.
- R3: `prod_valid` equals `op_valid` delayed by exactly two clock cycles, and the product in that cycle belongs to the pair accepted two cycles earlier.
- R4: Every nibble of `prod_bcd` lies in 0..9 whenever `prod_valid` is high.
- R5: A pair is accepted on every cycle that `op_valid` is high. Back-to-back pairs each produce their own result on consecutive cycles.
- R6: If either operand is zero, the product is all zero digits.
- R7: While `rst_n` is low and after it is released, `prod_valid` is 0 and `prod_bcd` is 0 until the first accepted pair reaches the output. A reset in the middle of traffic discards the pairs in flight.
- R8: The largest pair, 99999 × 99999, gives 9999800001 exactly.
- R9: Cycles with `op_valid` low do not disturb the data path, so `prod_bcd` keeps the last delivered product while `prod_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 4*DIGITS (20) | First operand, packed BCD |
| op_b | input | 4*DIGITS (20) | Second operand, packed BCD |
| prod_valid | output | 1 | Product present this cycle |
| prod_bcd | output | 8*DIGITS (40) | Product, packed BCD |

## Verification
The bench builds the block with its default values, five digits and a 17-bit binary width. With these values the largest operand pair is within reach, and that pair drives the 34-bit product into its top slice. The highest base-1000 group is then narrowed to a single BCD digit, so the truncated group and the Horner carry chain through all four slices are both exercised. Random operands over the whole 0..99999 range are applied back to back and with gaps, and the runs include a reset in the middle of traffic.

// File: rtl/bcd_rt_pkg.sv
package bcd_rt_pkg;
  localparam int SLICE_W = 10;  // binary slice per Horner step (radix 1024)
  localparam int KILO_W  = 10;  // bits of one base-1000 digit
  localparam int KILO_BCD = 3;  // BCD digits per base-1000 digit

  function automatic longint unsigned pow10(input int n);
    longint unsigned r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction
endpackage

// File: rtl/bcd_to_bin.sv
module bcd_to_bin #(
  parameter int DIGITS = 5,
  parameter int BIN_W  = 17
) (
  input  logic [4*DIGITS-1:0] bcd,
  output logic [BIN_W-1:0]    bin
);
  // Horner walk from the top digit: acc = acc*10 + digit, *10 = (x<<3)+(x<<1)
  function automatic logic [BIN_W-1:0] horner(input logic [4*DIGITS-1:0] v);
    logic [BIN_W-1:0] acc;
    acc = '0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      acc = (acc << 3) + (acc << 1) + BIN_W'(v[4*i +: 4]);
    end
    return acc;
  endfunction

  always_comb bin = horner(bcd);
endmodule

// File: rtl/bin_to_kilo.sv
module bin_to_kilo
  import bcd_rt_pkg::*;
#(
  parameter int PROD_W = 34,
  parameter int KD     = 4
) (
  input  logic [PROD_W-1:0]    bin,
  output logic [KD*KILO_W-1:0] kilo
);
  localparam int NSLICE = (PROD_W + SLICE_W - 1) / SLICE_W;

  // acc <- acc*1024 + slice, done digit-wise as acc*1000 + acc*24 + slice
  function automatic logic [KD*KILO_W-1:0] regroup(input logic [PROD_W-1:0] v);
    logic [NSLICE*SLICE_W-1:0] ext;
    logic [KILO_W-1:0] dig [KD];
    logic [15:0] t;
    logic [15:0] carry;
    logic [15:0] below;
    logic [15:0] save;
    logic [KD*KILO_W-1:0] packed_out;
    ext = '0;
    ext[PROD_W-1:0] = v;
    for (int j = 0; j < KD; j++) dig[j] = '0;
    for (int s = NSLICE - 1; s >= 0; s--) begin
      carry = '0;
      below = 16'(ext[s*SLICE_W +: SLICE_W]);
      for (int j = 0; j < KD; j++) begin
        save  = 16'(dig[j]);
        t     = save * 16'd24 + below + carry;
        dig[j] = KILO_W'(t % 16'd1000);
        carry = t / 16'd1000;
        below = save;
      end
    end
    for (int j = 0; j < KD; j++) packed_out[j*KILO_W +: KILO_W] = dig[j];
    return packed_out;
  endfunction

  always_comb kilo = regroup(bin);
endmodule

// File: rtl/kilo_to_bcd.sv
module kilo_to_bcd
  import bcd_rt_pkg::*;
#(
  parameter int NDIG = 3
) (
  input  logic [KILO_W-1:0] kval,
  output logic [4*NDIG-1:0] bcd
);
  localparam int SW = KILO_W + 4 * KILO_BCD;

  // shift-and-add-3: correct each BCD nibble >= 5 before every shift
  function automatic logic [4*NDIG-1:0] dabble(input logic [KILO_W-1:0] v);
    logic [SW-1:0] s;
    s = '0;
    s[KILO_W-1:0] = v;
    for (int it = 0; it < KILO_W; it++) begin
      for (int k = 0; k < KILO_BCD; k++) begin
        if (s[KILO_W + 4*k +: 4] >= 4'd5)
          s[KILO_W + 4*k +: 4] = s[KILO_W + 4*k +: 4] + 4'd3;
      end
      s = s << 1;
    end
    return s[KILO_W +: 4*NDIG];
  endfunction

  always_comb bcd = dabble(kval);
endmodule

// File: rtl/bcd_rt_mult.sv
module bcd_rt_mult
  import bcd_rt_pkg::*;
#(
  parameter int DIGITS = 5,
  parameter int BIN_W  = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [4*DIGITS-1:0]   op_a,
  input  logic [4*DIGITS-1:0]   op_b,
  output logic                  prod_valid,
  output logic [8*DIGITS-1:0]   prod_bcd
);
  localparam int PROD_W     = 2 * BIN_W;
  localparam int OUT_DIGITS = 2 * DIGITS;
  localparam int KD         = (OUT_DIGITS + KILO_BCD - 1) / KILO_BCD;
  localparam longint unsigned MAX_OP   = pow10(DIGITS) - 1;
  localparam longint unsigned MAX_PROD = MAX_OP * MAX_OP;

  // named internal events for the checks
  logic [BIN_W-1:0]         a_bin, b_bin;
  logic [PROD_W-1:0]        prod_bin_d;
  logic                     s1_valid;
  logic [PROD_W-1:0]        s1_prod;
  logic [KD*KILO_W-1:0]     kilo;
  logic [4*OUT_DIGITS-1:0]  bcd_d;

  bcd_to_bin #(.DIGITS(DIGITS), .BIN_W(BIN_W)) u_cvt_a (.bcd(op_a), .bin(a_bin));
  bcd_to_bin #(.DIGITS(DIGITS), .BIN_W(BIN_W)) u_cvt_b (.bcd(op_b), .bin(b_bin));

  assign prod_bin_d = PROD_W'(a_bin) * PROD_W'(b_bin);

  // stage 1: binary product
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_prod  <= '0;
    end else begin
      s1_valid <= op_valid;
      if (op_valid) s1_prod <= prod_bin_d;
    end
  end

  bin_to_kilo #(.PROD_W(PROD_W), .KD(KD)) u_regroup (.bin(s1_prod), .kilo(kilo));

  for (genvar g = 0; g < KD; g++) begin : g_expand
    localparam int ND = (g == KD - 1) ? (OUT_DIGITS - KILO_BCD * g) : KILO_BCD;
    logic [4*ND-1:0] grp;
    kilo_to_bcd #(.NDIG(ND)) u_dab (.kval(kilo[g*KILO_W +: KILO_W]), .bcd(grp));
    assign bcd_d[4*KILO_BCD*g +: 4*ND] = grp;
  end

  // stage 2: BCD result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_valid <= 1'b0;
      prod_bcd   <= '0;
    end else begin
      prod_valid <= s1_valid;
      if (s1_valid) prod_bcd <= bcd_d;
    end
  end

  // ---------------- assertions ----------------
  p_bin_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (64'(a_bin) <= MAX_OP) && (64'(b_bin) <= MAX_OP));

  p_prod_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> 64'(s1_prod) <= MAX_PROD);

  p_s1_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid == $past(op_valid));

  p_out_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prod_valid == $past(s1_valid));

  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (a_bin == '0 || b_bin == '0)) |=> s1_prod == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(prod_bcd));

  for (genvar k = 0; k < KD; k++) begin : g_kchk
    p_kilo_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> kilo[k*KILO_W +: KILO_W] < KILO_W'(1000));
  end

  for (genvar d = 0; d < OUT_DIGITS; d++) begin : g_dchk
    p_digit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      prod_valid |-> prod_bcd[4*d +: 4] <= 4'd9);
  end
endmodule

// File: tb/bcd_rt_mult_test.sv
module bcd_rt_mult_test;
  localparam int DIG = 5;
  localparam longint unsigned MAXV = 99999;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [4*DIG-1:0] op_a = '0, op_b = '0;
  logic prod_valid;
  logic [8*DIG-1:0] prod_bcd;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;
  int unsigned lcg = 32'h1234_5678;

  // behavioural expectation of the two-stage result
  bit              m_s1v = 0, m_ov = 0;
  longint unsigned m_s1p = 0, m_op = 0;
  string           m_s1t = "R2", m_ot = "R2";
  bit              early = 1'b1;

  always #5 clk = ~clk;

  bcd_rt_mult #(.DIGITS(DIG), .BIN_W(17)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .prod_valid(prod_valid), .prod_bcd(prod_bcd));

  function automatic logic [63:0] to_bcd(input longint unsigned v);
    logic [63:0] r;
    longint unsigned x;
    r = '0;
    x = v;
    for (int i = 0; i < 16; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic int unsigned next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return (lcg >> 8) % 100000;
  endfunction

  task automatic check(input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare at the falling edge, then drive the next pair and advance the model
  task automatic step(input bit v, input longint unsigned a, input longint unsigned b,
                      input string tag);
    logic [63:0] exp_bcd;
    @(negedge clk);
    check(early ? "R7" : "R3", "prod_valid", 64'(prod_valid), 64'(m_ov));
    exp_bcd = to_bcd(m_op);
    check(early ? "R7" : (m_ov ? m_ot : "R9"), "prod_bcd",
          64'(prod_bcd), 64'(exp_bcd[8*DIG-1:0]));
    if (prod_valid) begin
      for (int d = 0; d < 2*DIG; d++)
        check("R4", "digit range", 64'(prod_bcd[4*d +: 4] <= 4'd9), 64'd1);
    end
    if (m_ov) early = 1'b0;
    op_valid = v;
    op_a = to_bcd(a)[4*DIG-1:0];
    op_b = to_bcd(b)[4*DIG-1:0];
    m_ov = m_s1v;
    if (m_s1v) begin m_op = m_s1p; m_ot = m_s1t; end
    m_s1v = v;
    if (v) begin m_s1p = a * b; m_s1t = tag; end
  endtask

  function automatic string tag_of(input longint unsigned a, input longint unsigned b,
                                   input string dflt);
    if (a == MAXV && b == MAXV) return "R8";
    if (a == 0 || b == 0) return "R6";
    if (a == 1 || b == 1) return "R1";
    return dflt;
  endfunction

  task automatic pair(input longint unsigned a, input longint unsigned b, input string dflt);
    step(1'b1, a, b, tag_of(a, b, dflt));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, "R9");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_valid = 1'b0;
    m_s1v = 0; m_ov = 0; m_s1p = 0; m_op = 0;
    early = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", "prod_valid in reset", 64'(prod_valid), 64'd0);
    check("R7", "prod_bcd in reset", 64'(prod_bcd), 64'd0);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset();
    idle(3);
    // corner pairs with gaps
    pair(0, MAXV, "R2");        idle(1);
    pair(MAXV, 0, "R2");        idle(2);
    pair(MAXV, MAXV, "R2");     idle(1);
    pair(1, 12345, "R2");
    pair(54321, 1, "R2");       idle(2);
    pair(12345, 6789, "R2");
    pair(999, 1001, "R2");
    pair(1000, 1000, "R2");
    pair(1024, 1023, "R2");     idle(3);
    // back-to-back stream
    for (int i = 0; i < 300; i++) begin
      int unsigned a, b;
      a = next_rand();
      b = next_rand();
      pair(a, b, "R5");
    end
    // gapped stream
    for (int i = 0; i < 300; i++) begin
      int unsigned a, b;
      a = next_rand();
      b = next_rand();
      if ((lcg & 32'h3) == 0) step(1'b0, a, b, "R9");
      else pair(a, b, "R2");
    end
    // reset in the middle of traffic
    pair(77777, 88888, "R2");
    pair(99999, 12, "R2");
    do_reset();
    idle(2);
    pair(MAXV, MAXV, "R2");
    pair(0, 0, "R2");
    pair(31415, 27182, "R5");
    idle(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule